// File: doc/BRIEF.md
# Auto-Scrolling Test Pattern Sequencer

This block chooses which test pattern a display pattern generator shows. It does not draw pixels. It holds a list of sixteen time slots, and each slot carries a 4-bit pattern code. While scrolling is enabled, the block steps through the first N slots. It keeps each slot's pattern on screen for twice the programmed number of frame-start strobes. After the last active slot it returns to slot 1.

Software programs the block through a byte-wide register port with these addresses:

| Address | Contents |
|---|---|
| 0 | Frame-time value |
| 1 | Slot count |
| 2 to 9 | Slot pattern codes, two codes per byte |

A changed register value does not disturb the pattern that is already on screen. It is applied at the next slot change. The output is the current pattern code, together with a one-cycle strobe that marks each cycle in which the code changes.

Top module: `pattern_scroller`

## Requirements
- R1: After reset the registers hold the following values, and `pattern` is 1 with `pattern_chg` low:
  - frame time (address 0) = 30;
  - slot count (address 1) = 14;
  - slot i holds code i for slots 1 to 15;
  - slot 16 holds code 0.
- R2: Register addressing works as follows:
  - address 0 is the 8-bit frame time;
  - address 1 holds the slot count in bits 3:0;
  - address 2+k holds slot 2k+1 in bits 3:0 and slot 2k+2 in bits 7:4, for k = 0 to 7;
  - addresses 10 to 15 read 0, and a write to them changes no register.
- R3: Bits 7:4 of the slot-count register always read 0, whatever was written to them.
- R4: With scrolling enabled, each slot lasts exactly 2×F frame-start strobes, where F is the frame time. An F of 0 behaves as 1.
- R5: At each slot end the sequencer moves to the next slot. After slot N (the slot count) it wraps to slot 1. An N of 0 behaves as 1.
- R6: While `scroll_en` is low, the frame count is cleared and `pattern` shows slot 1's code one cycle after any change to it. Raising `scroll_en` starts at slot 1 with a fresh count.
- R7: The frame time and the slot codes are sampled only at a slot end. A write in the same cycle as a slot end is not seen until the following slot end.
- R8: If the slot count is lowered to or below the current slot number, the sequencer returns to slot 1 at the next slot end.
- R9: `pattern_chg` is high for exactly those cycles in which `pattern` differs from its value in the previous cycle.
- R10: `pattern` is registered. It takes the new slot's code at the clock edge that samples the strobe ending the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe at each video frame start |
| scroll_en | input | 1 | Enables auto-scrolling |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pattern | output | 4 | Currently selected pattern code |
| pattern_chg | output | 1 | Pulses in each cycle in which `pattern` changes |

## Verification
A register write and a slot end can land in the same clock cycle. This decides whether the new frame time or slot code is used at once or one slot later. The bench provokes the collision with a long random phase: frame strobes, random writes and short frame times, which make slot ends frequent. Small frame-time values are favoured so that writes often land on a slot end. A behavioural model applies every write only after it has evaluated the slot end, and the bench compares `pattern`, `pattern_chg` and the read data against that model on every clock.

// File: rtl/pscr_pkg.sv
package pscr_pkg;

  localparam int PSCR_SLOTS  = 16;
  localparam int PSCR_CODE_W = 4;
  localparam int PSCR_FT_W   = 8;
  localparam int PSCR_ADDR_W = 4;

  localparam int ADDR_FTIME = 0;
  localparam int ADDR_SCNT  = 1;
  localparam int ADDR_SLOT0 = 2;

  // frames per slot: twice the programmed value, zero counted as one
  function automatic int hold_frames(input int ftime);
    int f;
    f = (ftime == 0) ? 1 : ftime;
    return 2 * f;
  endfunction

  // slot index after a slot end, given the programmed slot count
  function automatic int next_slot(input int idx, input int cnt);
    int c;
    c = (cnt == 0) ? 1 : cnt;
    return (idx + 1 >= c) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/pscr_regfile.sv
module pscr_regfile #(
  parameter int SLOTS      = pscr_pkg::PSCR_SLOTS,
  parameter int CODE_W     = pscr_pkg::PSCR_CODE_W,
  parameter int FT_W       = pscr_pkg::PSCR_FT_W,
  parameter int ADDR_W     = pscr_pkg::PSCR_ADDR_W,
  parameter int RST_FTIME  = 30,
  parameter int RST_SCNT   = 14,
  localparam int DATA_W    = 2 * CODE_W,
  localparam int CNT_W     = $clog2(SLOTS),
  localparam int PAIRS     = SLOTS / 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [FT_W-1:0]              ftime,
  output logic [CNT_W-1:0]             slot_cnt,
  output logic [SLOTS-1:0][CODE_W-1:0] codes
);
  import pscr_pkg::*;

  logic [FT_W-1:0]              ftime_q;
  logic [CNT_W-1:0]             scnt_q;
  logic [SLOTS-1:0][CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftime_q <= FT_W'(RST_FTIME);
      scnt_q  <= CNT_W'(RST_SCNT);
    end else if (wr) begin
      if (addr == ADDR_W'(ADDR_FTIME)) ftime_q <= wdata[FT_W-1:0];
      if (addr == ADDR_W'(ADDR_SCNT))  scnt_q  <= wdata[CNT_W-1:0];
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam int PAIR = i / 2;
    localparam int LSB  = (i % 2) * CODE_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[i] <= CODE_W'(i + 1);
      else if (wr && addr == ADDR_W'(ADDR_SLOT0 + PAIR))
        code_q[i] <= wdata[LSB +: CODE_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_FTIME))
      rdata = DATA_W'(ftime_q);
    else if (addr == ADDR_W'(ADDR_SCNT))
      rdata = DATA_W'(scnt_q);
    else
      for (int k = 0; k < PAIRS; k++)
        if (addr == ADDR_W'(ADDR_SLOT0 + k))
          rdata = {code_q[2*k+1], code_q[2*k]};
  end

  assign ftime    = ftime_q;
  assign slot_cnt = scnt_q;
  assign codes    = code_q;

  // the reserved upper half of the slot-count register never shows a one
  always_comb begin
    if (rst_n && addr == ADDR_W'(ADDR_SCNT))
      p_resv_zero_r3: assert (rdata[DATA_W-1:CNT_W] == '0);
  end

endmodule

// File: rtl/pscr_frame_timer.sv
module pscr_frame_timer #(
  parameter int FT_W    = pscr_pkg::PSCR_FT_W,
  localparam int HOLD_W = FT_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            frame_start,
  input  logic [FT_W-1:0] ftime,
  output logic            slot_end
);
  import pscr_pkg::*;

  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_new;

  assign hold_new = HOLD_W'(hold_frames(int'(ftime)));
  assign slot_end = en && frame_start && (cnt_q == hold_q - HOLD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= HOLD_W'(hold_frames(30));
    end else if (!en) begin
      cnt_q  <= '0;
      hold_q <= hold_new;
    end else if (slot_end) begin
      cnt_q  <= '0;
      hold_q <= hold_new;
    end else if (frame_start) begin
      cnt_q  <= cnt_q + HOLD_W'(1);
    end
  end

  p_cnt_below_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < hold_q);

  p_off_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0);

  p_hold_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q[0] == 1'b0 && hold_q != '0);

endmodule

// File: rtl/pscr_slot_walker.sv
module pscr_slot_walker #(
  parameter int SLOTS   = pscr_pkg::PSCR_SLOTS,
  parameter int CODE_W  = pscr_pkg::PSCR_CODE_W,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         slot_end,
  input  logic [CNT_W-1:0]             slot_cnt,
  input  logic [SLOTS-1:0][CODE_W-1:0] codes,
  output logic [CODE_W-1:0]            pattern,
  output logic                         pattern_chg
);
  import pscr_pkg::*;

  logic [IDX_W-1:0]  idx_q, idx_next;
  logic [CODE_W-1:0] pat_q, pat_next;
  logic              chg_q;

  always_comb begin
    if (!en) begin
      idx_next = '0;
      pat_next = codes[0];
    end else if (slot_end) begin
      idx_next = IDX_W'(next_slot(int'(idx_q), int'(slot_cnt)));
      pat_next = codes[idx_next];
    end else begin
      idx_next = idx_q;
      pat_next = pat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pat_q <= CODE_W'(1);
      chg_q <= 1'b0;
    end else begin
      idx_q <= idx_next;
      pat_q <= pat_next;
      chg_q <= (pat_next != pat_q);
    end
  end

  assign pattern     = pat_q;
  assign pattern_chg = chg_q;

  p_step_or_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (idx_q == '0 || idx_q == $past(idx_q) + IDX_W'(1)));

  p_hold_between_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !slot_end) |=> $stable(pat_q));

  p_off_slot_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> idx_q == '0);

  p_chg_marks_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q == !$stable(pat_q));

endmodule

// File: rtl/pattern_scroller.sv
module pattern_scroller #(
  parameter int SLOTS   = pscr_pkg::PSCR_SLOTS,
  parameter int CODE_W  = pscr_pkg::PSCR_CODE_W,
  parameter int FT_W    = pscr_pkg::PSCR_FT_W,
  parameter int ADDR_W  = pscr_pkg::PSCR_ADDR_W,
  localparam int DATA_W = 2 * CODE_W,
  localparam int CNT_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              scroll_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CODE_W-1:0] pattern,
  output logic              pattern_chg
);

  logic [FT_W-1:0]              ftime;
  logic [CNT_W-1:0]             slot_cnt;
  logic [SLOTS-1:0][CODE_W-1:0] codes;
  logic                         slot_end;

  pscr_regfile #(
    .SLOTS(SLOTS), .CODE_W(CODE_W), .FT_W(FT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ftime(ftime), .slot_cnt(slot_cnt), .codes(codes)
  );

  pscr_frame_timer #(.FT_W(FT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(scroll_en), .frame_start(frame_start),
    .ftime(ftime), .slot_end(slot_end)
  );

  pscr_slot_walker #(.SLOTS(SLOTS), .CODE_W(CODE_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .en(scroll_en), .slot_end(slot_end),
    .slot_cnt(slot_cnt), .codes(codes),
    .pattern(pattern), .pattern_chg(pattern_chg)
  );

  // pattern may only move at a slot end or while scrolling is off
  p_move_needs_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll_en && !slot_end) |=> !pattern_chg);

endmodule

// File: tb/pattern_scroller_bench.sv
module pattern_scroller_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       scroll_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] pattern;
  logic       pattern_chg;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  int fs_mode = 0;
  int fs_div = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_scroller u_pattern_scroller (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .scroll_en(scroll_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pattern(pattern), .pattern_chg(pattern_chg)
  );

  // behavioural reference model
  int m_ft, m_sc, m_slot, m_fcnt, m_hold, m_pat, m_chg;
  int m_code[16];

  function automatic int m_read(input int a);
    if (a == 0) return m_ft;
    if (a == 1) return m_sc;
    if (a >= 2 && a <= 9) return m_code[2*(a-2)+1] * 16 + m_code[2*(a-2)];
    return 0;
  endfunction

  task automatic m_reset();
    m_ft = 30; m_sc = 14;
    for (int i = 0; i < 15; i++) m_code[i] = i + 1;
    m_code[15] = 0;
    m_slot = 0; m_fcnt = 0; m_hold = 60; m_pat = 1; m_chg = 0;
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      int old_pat, lim, f;
      old_pat = m_pat;
      f = (m_ft == 0) ? 1 : m_ft;
      if (!scroll_en) begin
        m_slot = 0; m_fcnt = 0; m_hold = 2 * f; m_pat = m_code[0];
      end else if (frame_start) begin
        if (m_fcnt + 1 == m_hold) begin
          lim = (m_sc == 0) ? 1 : m_sc;
          m_slot = (m_slot + 1 < lim) ? m_slot + 1 : 0;
          m_pat = m_code[m_slot];
          m_fcnt = 0;
          m_hold = 2 * f;
        end else m_fcnt++;
      end
      m_chg = (m_pat != old_pat) ? 1 : 0;
      if (reg_wr) begin
        int a;
        a = int'(reg_addr);
        if (a == 0) m_ft = int'(reg_wdata);
        else if (a == 1) m_sc = int'(reg_wdata) % 16;
        else if (a >= 2 && a <= 9) begin
          m_code[2*(a-2)]   = int'(reg_wdata) % 16;
          m_code[2*(a-2)+1] = int'(reg_wdata) / 16;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk({cur_req, " pattern"}, int'(pattern), m_pat);
      chk("R9 change strobe", int'(pattern_chg), m_chg);
      chk("R2 read data", int'(reg_rdata), m_read(int'(reg_addr)));
    end
  end

  // frame strobe generator
  always @(negedge clk) begin
    #1;
    fs_div = (fs_div + 1) % 3;
    case (fs_mode)
      1: frame_start = 1'b1;
      2: frame_start = (fs_div == 0);
      3: frame_start = ($urandom_range(1, 0) == 1);
      default: frame_start = 1'b0;
    endcase
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: literal reset values, independent of the model
    chk("R1 pattern after reset", int'(pattern), 1);
    chk("R1 strobe after reset", int'(pattern_chg), 0);
    reg_addr = 4'd0; #1; chk("R1 frame time", int'(reg_rdata), 30);
    reg_addr = 4'd1; #1; chk("R1 slot count", int'(reg_rdata), 14);
    for (int k = 0; k < 8; k++) begin
      reg_addr = 4'(2 + k); #1;
      chk("R1 slot pair", int'(reg_rdata), ((2*k + 2) % 16) * 16 + (2*k + 1));
    end
    for (int a = 10; a < 16; a++) begin
      reg_addr = 4'(a); #1; chk("R2 unmapped read", int'(reg_rdata), 0);
    end
    cmp_on = 1'b1;
    tick(1);

    // R2 / R3: map and reserved nibble
    cur_req = "R3";
    wr(1, 8'hA5);
    reg_addr = 4'd1; #1; chk("R3 reserved nibble", int'(reg_rdata), 5);
    wr(12, 8'hFF);
    for (int a = 0; a < 10; a++) begin
      reg_addr = 4'(a); #1; chk("R2 write to unmapped address", int'(reg_rdata), m_read(a));
    end
    wr(3, 8'h9C);
    reg_addr = 4'd3; #1; chk("R2 nibble order", int'(reg_rdata), 8'h9C);

    // R4 / R5: short frame time, four slots
    cur_req = "R5";
    wr(0, 1); wr(1, 4);
    tick(2);
    scroll_en = 1'b1; fs_mode = 1;
    tick(40);
    fs_mode = 2;
    tick(60);
    cur_req = "R4";
    wr(0, 0);
    tick(60);
    wr(0, 30);
    tick(300);
    wr(0, 255);
    tick(1100);

    // R6: disabled mode follows slot 1, restarts on enable
    cur_req = "R6";
    wr(0, 2); fs_mode = 1;
    tick(15);
    scroll_en = 1'b0;
    tick(3);
    wr(2, 8'h37);
    tick(3);
    scroll_en = 1'b1;
    tick(30);

    // R8: shrink the slot count under the current slot
    cur_req = "R8";
    wr(0, 1); wr(1, 8);
    scroll_en = 1'b0; tick(1); scroll_en = 1'b1;
    tick(13);
    wr(1, 3);
    tick(20);

    // R5: slot count of zero
    cur_req = "R5";
    wr(1, 0);
    tick(20);

    // R7 / R10: random writes colliding with slot ends
    cur_req = "R7";
    fs_mode = 3;
    for (int n = 0; n < 30000; n++) begin
      if ($urandom_range(199, 0) == 0) scroll_en = ~scroll_en;
      if ($urandom_range(5, 0) == 0) begin
        int a;
        a = $urandom_range(11, 0);
        reg_wr = 1'b1;
        reg_addr = 4'(a);
        reg_wdata = (a == 0) ? 8'($urandom_range(3, 0)) : 8'($urandom_range(255, 0));
      end else begin
        reg_wr = 1'b0;
        reg_addr = 4'($urandom_range(15, 0));
      end
      tick(1);
    end
    reg_wr = 1'b0;
    cur_req = "R10";
    fs_mode = 1; scroll_en = 1'b1;
    tick(50);
    summary();
  end

endmodule